// File: doc/BRIEF.md
# Fractional Clock-Enable Divider Mux

This block picks one of ten clock-enable strobe sources and thins the chosen strobe train by a fixed-point divisor. The divisor has an integer part and a fractional part. Each instance fixes the width of both parts through parameters. A phase accumulator approximates the fractional ratio, so over a long run the output strobe rate is the input strobe rate times 2^FRAC_BITS divided by the divisor value. A clock generator uses one instance per consumer: it drives the source strobes, a control word holding an enable bit and a source select, and a divisor word. The block returns the divided strobe and a busy flag.

Source 0 is tied to ground. Sources 1 to 3 are shared: the main oscillator and two test clocks. Sources 4 to 9 differ per instance, and any of them can be tied to ground by a per-instance mask. When both widths are set to zero, the divider is left out and the selected strobe passes through unchanged. The output is always registered, so it follows the source by one cycle.

Top module: `frac_clk_mux`

## Requirements
- R1: The control word bits [3:0] select the source (0 to 9). Select values 10 to 15 pick no source. Strobes on sources other than the selected one never produce an output strobe.
- R2: Source 0 never produces an output strobe. Neither does any source whose bit is set in the FORCE_GND mask. Sources 1 to 9 that are not masked do produce output strobes.
- R3: The control word bit 4 enables the block. While it is low, no output strobe is produced. busy_o equals the enable bit of the previous cycle.
- R4: The divisor value is the field div_i[12+INT_BITS-1 : 12-FRAC_BITS], which is INT_BITS+FRAC_BITS bits wide. All other bits of div_i have no effect.
- R5: A divisor field of zero produces no output strobes.
- R6: When the field D is greater than 2^FRAC_BITS, k selected strobes that start from a cleared accumulator produce exactly floor(k*2^FRAC_BITS/D) output strobes. This holds whatever the spacing between the strobes.
- R7: When the field D is nonzero and not greater than 2^FRAC_BITS, every selected strobe produces one output strobe.
- R8: When INT_BITS and FRAC_BITS are both zero, every selected strobe produces one output strobe and div_i is ignored.
- R9: An output strobe appears in the cycle after the source strobe that causes it.
- R10: A cycle in which the select or the enable differs from the previous cycle clears the accumulator and produces no output strobe.
- R11: After reset, div_stb_o and busy_o are 0 and the accumulator is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Source enable strobes, one bit per source |
| ctl_i | input | 8 | Control: [3:0] source select, [4] enable, [7:5] unused |
| div_i | input | 32 | Divisor word; the field sits around bit 12 |
| div_stb_o | output | 1 | Divided output strobe |
| busy_o | output | 1 | Enable bit of the previous cycle |

## Verification
Every divisor value of a 4.2 instance is swept with dense strobes and with strobes spaced one or two cycles apart, and junk is placed in the div_i bits outside the field. This separates the floor-count rule from the one-per-strobe region at or below 1.0, from the zero stop, and from a wrong field slice. A bypass instance runs alongside under the same stimulus and must pass every strobe. All sixteen select codes are tried with a strobe on the selected source and with strobes on every other source. This separates grounded, masked, out-of-range and live sources. A switch of source while the accumulator is half full tells a cleared accumulator from a carried one, and a single isolated strobe pins the one-cycle latency.

// File: rtl/fcm_pkg.sv
`timescale 1ns/1ps
package fcm_pkg;

    localparam int FCM_SEL_W   = 4;
    localparam int FCM_CTL_W   = 8;
    localparam int FCM_EN_BIT  = 4;
    localparam int FCM_DIV_W   = 32;
    localparam int FCM_INT_LSB = 12;

    typedef struct packed {
        logic                 en;
        logic [FCM_SEL_W-1:0] sel;
    } fcm_ctl_t;

    typedef enum logic [1:0] {
        FCM_STOP  = 2'd0,
        FCM_EVERY = 2'd1,
        FCM_ACCUM = 2'd2
    } fcm_mode_e;

    function automatic fcm_ctl_t fcm_decode(input logic [FCM_CTL_W-1:0] w);
        fcm_ctl_t c;
        c.en  = w[FCM_EN_BIT];
        c.sel = w[FCM_SEL_W-1:0];
        return c;
    endfunction

    // width of the divisor field port, never below one bit
    function automatic int fcm_fw(input int ib, input int fb);
        return (ib + fb > 0) ? ib + fb : 1;
    endfunction

endpackage

// File: rtl/fcm_src_select.sv
`timescale 1ns/1ps
module fcm_src_select
    import fcm_pkg::*;
#(
    parameter int               NUM_SRC   = 10,
    parameter logic [NUM_SRC-1:0] FORCE_GND = '0
) (
    input  logic [NUM_SRC-1:0]   src_i,
    input  fcm_ctl_t             ctl_i,
    output logic                 stb_o
);
    localparam int CODES = 1 << FCM_SEL_W;

    logic [CODES-1:0] live;

    for (genvar g = 0; g < CODES; g++) begin : g_live
        if (g == 0 || g >= NUM_SRC) begin : g_gnd
            assign live[g] = 1'b0;
        end else if (FORCE_GND[g]) begin : g_forced
            assign live[g] = 1'b0;
        end else begin : g_src
            assign live[g] = src_i[g];
        end
    end

    logic unused_src0;
    assign unused_src0 = src_i[0];

    assign stb_o = ctl_i.en & live[ctl_i.sel];
endmodule

// File: rtl/fcm_div_extract.sv
`timescale 1ns/1ps
module fcm_div_extract
    import fcm_pkg::*;
#(
    parameter int INT_BITS  = 12,
    parameter int FRAC_BITS = 12
) (
    input  logic [FCM_DIV_W-1:0]                    div_i,
    output logic [fcm_fw(INT_BITS, FRAC_BITS)-1:0]  field_o
);
    localparam int DW  = INT_BITS + FRAC_BITS;
    localparam int TOP = FCM_INT_LSB + INT_BITS - 1;

    logic unused_div;
    assign unused_div = ^div_i;

    if (DW == 0) begin : g_none
        assign field_o = '0;
    end else begin : g_field
        assign field_o = div_i[TOP -: DW];
    end
endmodule

// File: rtl/fcm_phase_acc.sv
`timescale 1ns/1ps
module fcm_phase_acc
    import fcm_pkg::*;
#(
    parameter int INT_BITS  = 12,
    parameter int FRAC_BITS = 12
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    stb_i,
    input  logic                                    clear_i,
    input  logic [fcm_fw(INT_BITS, FRAC_BITS)-1:0]  field_i,
    output logic                                    stb_o
);
    localparam int DW = INT_BITS + FRAC_BITS;
    localparam int AW = DW + 1;

    if (DW == 0) begin : g_pass
        logic unused_field;
        assign unused_field = ^field_i;

        always_ff @(posedge clk) begin
            if (rst) stb_o <= 1'b0;
            else     stb_o <= stb_i & ~clear_i;
        end
    end else begin : g_frac
        localparam logic [AW-1:0] ONE = AW'(1) << FRAC_BITS;

        logic [AW-1:0] acc_q, acc_d, sum, dv;
        logic          fire;
        fcm_mode_e     mode;

        assign dv  = {1'b0, field_i};
        assign sum = acc_q + ONE;

        always_comb begin
            if (dv == '0)       mode = FCM_STOP;
            else if (dv <= ONE) mode = FCM_EVERY;
            else                mode = FCM_ACCUM;
        end

        always_comb begin
            acc_d = acc_q;
            fire  = 1'b0;
            case (mode)
                FCM_STOP: acc_d = '0;
                FCM_EVERY: begin
                    acc_d = '0;
                    fire  = stb_i;
                end
                FCM_ACCUM: begin
                    if (stb_i) begin
                        if (sum >= dv) begin
                            fire  = 1'b1;
                            acc_d = sum - dv;
                        end else begin
                            acc_d = sum;
                        end
                    end
                end
                default: acc_d = '0;
            endcase
            if (clear_i) begin
                acc_d = '0;
                fire  = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
                stb_o <= 1'b0;
            end else begin
                acc_q <= acc_d;
                stb_o <= fire;
            end
        end
    end
endmodule

// File: rtl/frac_clk_mux.sv
`timescale 1ns/1ps
module frac_clk_mux
    import fcm_pkg::*;
#(
    parameter int                 NUM_SRC   = 10,
    parameter int                 INT_BITS  = 12,
    parameter int                 FRAC_BITS = 12,
    parameter logic [NUM_SRC-1:0] FORCE_GND = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [7:0]         ctl_i,
    input  logic [31:0]        div_i,
    output logic               div_stb_o,
    output logic               busy_o
);
    localparam int FW = fcm_fw(INT_BITS, FRAC_BITS);

    fcm_ctl_t ctl, ctl_prev;
    logic     changed, sel_stb;
    logic [FW-1:0] field;

    assign ctl = fcm_decode(ctl_i);

    logic unused_ctl;
    assign unused_ctl = ^ctl_i[7:5];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_prev <= '0;
            busy_o   <= 1'b0;
        end else begin
            ctl_prev <= ctl;
            busy_o   <= ctl.en;
        end
    end

    assign changed = (ctl != ctl_prev);

    fcm_src_select #(
        .NUM_SRC   (NUM_SRC),
        .FORCE_GND (FORCE_GND)
    ) u_sel (
        .src_i (src_i),
        .ctl_i (ctl),
        .stb_o (sel_stb)
    );

    fcm_div_extract #(
        .INT_BITS  (INT_BITS),
        .FRAC_BITS (FRAC_BITS)
    ) u_ext (
        .div_i   (div_i),
        .field_o (field)
    );

    fcm_phase_acc #(
        .INT_BITS  (INT_BITS),
        .FRAC_BITS (FRAC_BITS)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (sel_stb),
        .clear_i (changed | ~ctl.en),
        .field_i (field),
        .stb_o   (div_stb_o)
    );
endmodule

// File: rtl/frac_clk_mux_chk.sv
`timescale 1ns/1ps
module frac_clk_mux_chk #(
    parameter int                 NUM_SRC   = 10,
    parameter int                 INT_BITS  = 12,
    parameter int                 FRAC_BITS = 12,
    parameter logic [NUM_SRC-1:0] FORCE_GND = '0
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic [7:0]         ctl_i,
    input logic [31:0]        div_i,
    input logic               div_stb_o,
    input logic               busy_o
);
    localparam int DW = INT_BITS + FRAC_BITS;

    logic       en;
    logic [3:0] sel;
    logic [4:0] seen_q;
    logic [15:0] pad;
    logic       live, switched, field_zero;

    assign en  = ctl_i[4];
    assign sel = ctl_i[3:0];

    always_comb begin
        pad = '0;
        for (int i = 1; i < NUM_SRC && i < 16; i++)
            pad[i] = src_i[i] & ~FORCE_GND[i];
    end
    assign live = en & pad[sel];

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= {en, sel};
    end
    assign switched = ({en, sel} != seen_q);

    if (DW > 0) begin : g_zero
        logic [31:0] shifted;
        assign shifted    = div_i >> (12 - FRAC_BITS);
        assign field_zero = (shifted & 32'((64'd1 << DW) - 1)) == 32'd0;
    end else begin : g_nozero
        assign field_zero = 1'b0;
    end

    // R3
    busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> busy_o == $past(en));

    // R3
    off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !div_stb_o);

    // R1
    needs_live_src_chk: assert property (@(posedge clk) disable iff (rst)
        !live |=> !div_stb_o);

    // R10
    quiet_on_switch_chk: assert property (@(posedge clk) disable iff (rst)
        switched |=> !div_stb_o);

    // R5
    zero_div_stop_chk: assert property (@(posedge clk) disable iff (rst)
        field_zero |=> !div_stb_o);

    if (DW == 0) begin : g_bypass
        // R8
        bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
            (live && !switched) |=> div_stb_o);
    end
endmodule

bind frac_clk_mux frac_clk_mux_chk #(
    .NUM_SRC   (NUM_SRC),
    .INT_BITS  (INT_BITS),
    .FRAC_BITS (FRAC_BITS),
    .FORCE_GND (FORCE_GND)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .ctl_i     (ctl_i),
    .div_i     (div_i),
    .div_stb_o (div_stb_o),
    .busy_o    (busy_o)
);

// File: tb/frac_clk_mux_bench.sv
`timescale 1ns/1ps
module frac_clk_mux_bench;
    localparam logic [9:0] MASK_A = 10'b00_1000_0000;  // source 7 grounded
    localparam logic [31:0] JUNK  = 32'hC3C3_03FF;     // bits outside [15:10]

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  src = '0;
    logic [7:0]  ctl = '0;
    logic [31:0] div = '0;
    logic        stb_a, busy_a, stb_b, busy_b;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frac_clk_mux #(.NUM_SRC(10), .INT_BITS(4), .FRAC_BITS(2), .FORCE_GND(MASK_A))
    u_frac_clk_mux (.clk(clk), .rst(rst), .src_i(src), .ctl_i(ctl), .div_i(div),
                    .div_stb_o(stb_a), .busy_o(busy_a));

    frac_clk_mux #(.NUM_SRC(10), .INT_BITS(0), .FRAC_BITS(0), .FORCE_GND(10'b0))
    u_frac_clk_mux_bypass (.clk(clk), .rst(rst), .src_i(src), .ctl_i(ctl), .div_i(div),
                           .div_stb_o(stb_b), .busy_o(busy_b));

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic arm(input logic [3:0] sel);
        @(negedge clk); ctl = 8'h00;
        @(negedge clk); ctl = {3'b000, 1'b1, sel};
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input logic [9:0] pat, input int k, input int gap,
                         output int ca, output int cb);
        ca = 0; cb = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk); ca += int'(stb_a); cb += int'(stb_b); src = pat;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); ca += int'(stb_a); cb += int'(stb_b); src = '0;
            end
        end
        @(negedge clk); ca += int'(stb_a); cb += int'(stb_b); src = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ca += int'(stb_a); cb += int'(stb_b);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int ca, cb, exp_a, exp_b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 stb after reset", int'(stb_a), 0);
        chk("R11 busy after reset", int'(busy_a), 0);

        // R3 busy follows enable
        div = JUNK | (32'd8 << 10);
        arm(4'd1);
        chk("R3 busy when enabled", int'(busy_a), 1);

        // R9 latency: ratio 1.0
        div = JUNK | (32'd4 << 10);
        arm(4'd1);
        @(negedge clk); src = 10'b10;
        @(negedge clk); chk("R9 strobe one cycle later", int'(stb_a), 1); src = '0;
        @(negedge clk); chk("R9 single strobe only", int'(stb_a), 0);

        // R4 R5 R6 R7 R8 divisor sweep, dense and spaced strobes
        for (int d = 0; d < 64; d++) begin
            div = JUNK | (32'(d) << 10);
            arm(4'd1);
            burst(10'b10, 24, d % 3, ca, cb);
            exp_a = (d == 0) ? 0 : (d <= 4) ? 24 : (96 / d);
            chk($sformatf("R4/R5/R6/R7 count D=%0d", d), ca, exp_a);
            chk($sformatf("R8 bypass count D=%0d", d), cb, 24);
        end

        // R1 R2 source select sweep, ratio 2.0
        div = JUNK | (32'd8 << 10);
        for (int s = 0; s < 16; s++) begin
            arm(4'(s));
            burst((s < 10) ? (10'b1 << s) : 10'h3FF, 8, 0, ca, cb);
            exp_a = (s >= 1 && s <= 9 && s != 7) ? 4 : 0;
            exp_b = (s >= 1 && s <= 9) ? 8 : 0;
            chk($sformatf("R2 selected source %0d", s), ca, exp_a);
            chk($sformatf("R1 bypass selected source %0d", s), cb, exp_b);
            if (s < 10) begin
                burst(~(10'b1 << s), 8, 0, ca, cb);
                chk($sformatf("R1 other sources sel=%0d", s), ca + cb, 0);
            end
        end

        // R3 disabled: no output, busy low
        @(negedge clk); ctl = 8'h01;
        burst(10'b10, 8, 0, ca, cb);
        chk("R3 disabled no strobes", ca + cb, 0);
        chk("R3 busy when disabled", int'(busy_a), 0);

        // R10 switch clears accumulator, ratio 2.0
        div = JUNK | (32'd8 << 10);
        arm(4'd1);
        ca = 0; cb = 0;
        @(negedge clk); src = 10'b0000000010;
        @(negedge clk); ca += int'(stb_a); cb += int'(stb_b);
        src = 10'b0000000100; ctl = 8'h12;
        @(negedge clk); ca += int'(stb_a); cb += int'(stb_b);
        src = 10'b0000000100;
        @(negedge clk); ca += int'(stb_a); cb += int'(stb_b); src = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ca += int'(stb_a); cb += int'(stb_b);
        end
        chk("R10 accumulator cleared on switch", ca, 0);
        chk("R10 bypass suppressed at switch", cb, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule